// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Conditions

This block is a port of general-purpose pins behind a small word-wide register interface. Each pin can be an output, driving a value held in a data latch, or an input, whose level is brought into the clock domain by a two-stage synchronizer. Software reads the synchronized levels directly. It also reads a merged data view, which shows the latch for output pins and the pad level for input pins.

Every pin can also raise an interrupt. Each pin has a 2-bit trigger condition: level low, level high, rising edge or falling edge. A per-pin "both edges" bit overrides that condition. Each detection sets a sticky status bit, and software clears these bits by writing ones. A per-pin enable gates each status bit into one of two combined interrupt lines: one line serves the lower half of the pins, the other serves the upper half.

The register port has a write strobe, a byte address, write data and combinational read data. The pad side has the raw pad inputs, the output values and the per-pin output enables.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, every register reads zero, `padOut` and `padOe` are all zero, and both interrupt lines are low.
- R2: A write to offset 0x04 (direction) sets `padOe` to the written value from the next cycle. `padOut` always equals the data latch, which is written at offset 0x00.
- R3: Offset 0x08 reads the pad levels two clock edges after they are applied. Offset 0x00 reads the data latch for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R4: Trigger codes are 0 for low level, 1 for high level, 2 for a rising edge and 3 for a falling edge. Pin n below 16 takes its code from bits [2n+1:2n] of offset 0x0C. Pin n of 16 or above takes its code from bits [2(n-16)+1:2(n-16)] of offset 0x10.
- R5: When a pin's bit at offset 0x1C is 1, both a rising and a falling edge set its status bit, and its trigger code is ignored.
- R6: A status bit at offset 0x18 sets on the third clock edge after the pad change that meets its condition. It sets whether or not the pin is enabled at offset 0x14.
- R7: Writing 1 to a bit at offset 0x18 clears it, and writing 0 leaves it unchanged. If the pin's condition holds in the same cycle, the bit stays set.
- R8: `irqLow` is the OR of status AND enable over pins 0-15, and `irqHigh` is the same over pins 16-31. An enable register of zero keeps both lines low.
- R9: Offsets 0x20 and above read zero, and writes to them change no register.
- R10: Direction, both trigger registers, the enable register and the both-edges register read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| padIn | input | 32 | Raw pad levels |
| padOut | output | 32 | Values driven onto the pads |
| padOe | output | 32 | Per-pin output enables |
| irqLow | output | 1 | Combined interrupt for pins 0-15 |
| irqHigh | output | 1 | Combined interrupt for pins 16-31 |

## Verification
A register write takes effect at the next edge, and read data reflects it in the same low phase. A pad change shows at offset 0x08 after two edges and in the status bits and interrupt lines after three. The bench drives inputs just after the falling edge and samples shortly after. Its reference model advances on the same rising edges as the design, with a synchronizer, previous-sample and status pipeline of the same depths. The directed status checks count out the two-edge and three-edge points against literal values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trigCode_t;

  typedef enum logic [3:0] {
    SEL_DATA,
    SEL_DIR,
    SEL_PAD,
    SEL_CFG_LO,
    SEL_CFG_HI,
    SEL_MASK,
    SEL_STAT,
    SEL_BOTH,
    SEL_NONE
  } rdSel_t;

  typedef struct packed {
    logic   setData;
    logic   setDir;
    logic   setCfgLo;
    logic   setCfgHi;
    logic   setMask;
    logic   clrStat;
    logic   setBoth;
    rdSel_t rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output gpioStrobe_t       strb
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + REG_IDX_W - 1;

  logic                 inWindow;
  logic [REG_IDX_W-1:0] regIdx;
  logic                 doWrite;

  assign regIdx   = addr[IDX_MSB:IDX_LSB];
  assign inWindow = (addr[ADDR_W-1:IDX_MSB+1] == '0) && (addr[IDX_LSB-1:0] == '0);
  assign doWrite  = wrEn && inWindow;

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (inWindow) begin
      case (regIdx)
        3'd0: begin strb.rdSel = SEL_DATA;   strb.setData  = doWrite; end
        3'd1: begin strb.rdSel = SEL_DIR;    strb.setDir   = doWrite; end
        3'd2: begin strb.rdSel = SEL_PAD;                             end
        3'd3: begin strb.rdSel = SEL_CFG_LO; strb.setCfgLo = doWrite; end
        3'd4: begin strb.rdSel = SEL_CFG_HI; strb.setCfgHi = doWrite; end
        3'd5: begin strb.rdSel = SEL_MASK;   strb.setMask  = doWrite; end
        3'd6: begin strb.rdSel = SEL_STAT;   strb.clrStat  = doWrite; end
        default: begin strb.rdSel = SEL_BOTH; strb.setBoth = doWrite; end
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.setData, strb.setDir, strb.setCfgLo, strb.setCfgHi,
                strb.setMask, strb.clrStat, strb.setBoth}) <= 1); // R9

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |-> !(strb.setData || strb.setDir || strb.setMask || strb.clrStat)); // R9

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_CNT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  gpioStrobe_t        strb,
  input  logic [PIN_CNT-1:0] wrData,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] rdData,
  output logic               irqLow,
  output logic               irqHigh
);

  localparam int HALF = PIN_CNT / 2;

  logic [PIN_CNT-1:0] dataReg, dirReg, cfgLo, cfgHi, maskReg, statReg, bothReg;
  logic [PIN_CNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_CNT-1:0] syncVal, prevVal, hitVec, pending;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      cfgLo   <= '0;
      cfgHi   <= '0;
      maskReg <= '0;
      bothReg <= '0;
    end else begin
      if (strb.setData)  dataReg <= wrData;
      if (strb.setDir)   dirReg  <= wrData;
      if (strb.setCfgLo) cfgLo   <= wrData;
      if (strb.setCfgHi) cfgHi   <= wrData;
      if (strb.setMask)  maskReg <= wrData;
      if (strb.setBoth)  bothReg <= wrData;
    end
  end

  // Input synchronizer
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= padIn;
      else             syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end
  assign syncVal = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;
  end

  // Per-pin condition detection
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    logic [1:0] code;
    logic       cur, old;
    if (p < HALF) begin : g_lo
      assign code = cfgLo[2*p +: 2];
    end else begin : g_hi
      assign code = cfgHi[2*(p-HALF) +: 2];
    end
    assign cur = syncVal[p];
    assign old = prevVal[p];
    always_comb begin
      if (bothReg[p]) begin
        hitVec[p] = cur ^ old;
      end else begin
        case (trigCode_t'(code))
          TRIG_LOW:  hitVec[p] = !cur;
          TRIG_HIGH: hitVec[p] = cur;
          TRIG_RISE: hitVec[p] = cur && !old;
          default:   hitVec[p] = !cur && old;
        endcase
      end
    end
  end

  // Sticky status, write-one-to-clear, detection wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statReg <= '0;
    else       statReg <= (statReg & ~(strb.clrStat ? wrData : '0)) | hitVec;
  end

  assign pending = statReg & maskReg;
  assign irqLow  = |pending[HALF-1:0];
  assign irqHigh = |pending[PIN_CNT-1:HALF];

  assign padOut = dataReg;
  assign padOe  = dirReg;

  always_comb begin
    case (strb.rdSel)
      SEL_DATA:   rdData = (dataReg & dirReg) | (syncVal & ~dirReg);
      SEL_DIR:    rdData = dirReg;
      SEL_PAD:    rdData = syncVal;
      SEL_CFG_LO: rdData = cfgLo;
      SEL_CFG_HI: rdData = cfgHi;
      SEL_MASK:   rdData = maskReg;
      SEL_STAT:   rdData = statReg;
      SEL_BOTH:   rdData = bothReg;
      default:    rdData = '0;
    endcase
  end

  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((statReg & $past(hitVec)) == $past(hitVec))); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrStat) |=> (($past(statReg) & ~statReg) == '0)); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStat |=> ((statReg & $past(wrData & ~hitVec)) == '0)); // R7

  AST_DIR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDir |=> (padOe == $past(wrData))); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> (!irqLow && !irqHigh)); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_CNT = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PIN_CNT-1:0] wrData,
  output logic [PIN_CNT-1:0] rdData,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic               irqLow,
  output logic               irqHigh
);

  gpioStrobe_t strb;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  gpio_port_dp #(.PIN_CNT(PIN_CNT), .SYNC_STAGES(2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (rdData),
    .irqLow  (irqLow),
    .irqHigh (irqHigh)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rstN) |-> (padOe == '0 && padOut == '0 && !irqLow && !irqHigh)); // R1

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqLow, irqHigh;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  // Reference model
  logic [31:0] mData, mDir, mCfgLo, mCfgHi, mMask, mStat, mBoth;
  logic [31:0] mS1, mS2, mPrev;

  function automatic logic [31:0] hitsOf(logic [31:0] cur, logic [31:0] old,
                                         logic [31:0] lo, logic [31:0] hi,
                                         logic [31:0] both);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      if (both[i]) h[i] = cur[i] ^ old[i];
      else case (c)
        2'd0: h[i] = !cur[i];
        2'd1: h[i] = cur[i];
        2'd2: h[i] = cur[i] && !old[i];
        default: h[i] = !cur[i] && old[i];
      endcase
    end
    return h;
  endfunction

  function automatic logic [31:0] modelRead(logic [5:0] a);
    if (a[5] || a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return (mData & mDir) | (mS2 & ~mDir);
      3'd1: return mDir;
      3'd2: return mS2;
      3'd3: return mCfgLo;
      3'd4: return mCfgHi;
      3'd5: return mMask;
      3'd6: return mStat;
      default: return mBoth;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {mData, mDir, mCfgLo, mCfgHi, mMask, mStat, mBoth} <= '0;
      {mS1, mS2, mPrev} <= '0;
    end else begin
      logic clr;
      clr = wrEn && addr == 6'h18;
      mS1 <= padIn;
      mS2 <= mS1;
      mPrev <= mS2;
      mStat <= (mStat & ~(clr ? wrData : 32'h0)) | hitsOf(mS2, mPrev, mCfgLo, mCfgHi, mBoth);
      if (wrEn && addr == 6'h00) mData  <= wrData;
      if (wrEn && addr == 6'h04) mDir   <= wrData;
      if (wrEn && addr == 6'h0C) mCfgLo <= wrData;
      if (wrEn && addr == 6'h10) mCfgHi <= wrData;
      if (wrEn && addr == 6'h14) mMask  <= wrData;
      if (wrEn && addr == 6'h1C) mBoth  <= wrData;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(logic [5:0] a);
    if (a[5] || a[1:0] != 2'b00) return "R9";
    case (a[4:2])
      3'd0, 3'd2: return "R3";
      3'd6: return "R6/R7";
      default: return "R10";
    endcase
  endfunction

  task automatic checkRead(logic [5:0] a);
    logic [31:0] e;
    addr = a;
    #1;
    e = modelRead(a);
    chk(rdData === e, reqOf(a), rdData, e);
  endtask

  task automatic checkPins();
    logic [31:0] pend;
    pend = mStat & mMask;
    chk(padOut === mData && padOe === mDir, "R2", padOe, mDir);
    chk(irqLow === |pend[15:0] && irqHigh === |pend[31:16], "R8",
        {30'd0, irqHigh, irqLow}, {30'd0, |pend[31:16], |pend[15:0]});
  endtask

  task automatic step();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeReg(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5EED1);
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 6'(a * 4);
      #1;
      chk(rdData === 32'h0, "R1", rdData, 32'h0);
    end
    chk(padOe === 0 && padOut === 0 && !irqLow && !irqHigh, "R1", padOe | padOut, 32'h0);
    rstN = 1'b1;
    step();

    // R2: direction and data drive the pads
    writeReg(6'h00, 32'hA5A5_A5A5);
    writeReg(6'h04, 32'h0000_00FF);
    #1;
    chk(padOe === 32'h0000_00FF, "R2", padOe, 32'h0000_00FF);
    chk(padOut === 32'hA5A5_A5A5, "R2", padOut, 32'hA5A5_A5A5);
    padIn = 32'h0F0F_0000;
    step(); step(); #1;
    // R3: pad visible two edges after change; data view merges by direction
    addr = 6'h08; #1;
    chk(rdData === 32'h0F0F_0000, "R3", rdData, 32'h0F0F_0000);
    addr = 6'h00; #1;
    chk(rdData === 32'h0F0F_00A5, "R3", rdData, 32'h0F0F_00A5);

    // R9: unmapped write ignored, reads zero
    writeReg(6'h20, 32'hFFFF_FFFF);
    writeReg(6'h3C, 32'hFFFF_FFFF);
    checkRead(6'h20);
    checkRead(6'h14);
    checkRead(6'h1C);

    // R4/R6: pin 20 rising edge in the upper config register, bits 9:8 = 2
    padIn = 32'h0;
    writeReg(6'h10, 32'h0000_0200 | 32'h5555_5455 & ~32'h0000_0300);
    writeReg(6'h14, 32'h0010_0000);
    repeat (3) step();
    writeReg(6'h18, 32'hFFFF_FFFF);
    padIn[20] = 1'b1;
    step(); step(); addr = 6'h18; #1;
    chk(rdData[20] === 1'b0 && !irqHigh, "R6", {31'd0, rdData[20]}, 32'd0);
    step(); #1;
    chk(rdData[20] === 1'b1, "R6", {31'd0, rdData[20]}, 32'd1);
    chk(irqHigh === 1'b1, "R8", {31'd0, irqHigh}, 32'd1);

    // R8: enable of zero blocks both lines
    writeReg(6'h14, 32'h0);
    #1;
    chk(!irqLow && !irqHigh, "R8", {30'd0, irqHigh, irqLow}, 32'd0);

    // R7: level-high condition re-sets on the same edge as a clear
    writeReg(6'h10, 32'h0000_0100);
    writeReg(6'h18, 32'h0010_0000);
    addr = 6'h18; #1;
    chk(rdData[20] === 1'b1, "R7", {31'd0, rdData[20]}, 32'd1);
    writeReg(6'h10, 32'h0000_0200);
    step();
    writeReg(6'h18, 32'h0010_0000);
    addr = 6'h18; #1;
    chk(rdData[20] === 1'b0, "R7", {31'd0, rdData[20]}, 32'd0);

    // R5: both-edges on pin 3 with a rise code, falling edge still latches
    writeReg(6'h0C, 32'h0000_0080);
    writeReg(6'h1C, 32'h0000_0008);
    padIn[3] = 1'b1;
    repeat (4) step();
    writeReg(6'h18, 32'h0000_0008);
    padIn[3] = 1'b0;
    repeat (3) step();
    addr = 6'h18; #1;
    chk(rdData[3] === 1'b1, "R5", {31'd0, rdData[3]}, 32'd1);

    // Random phase checked against the model (R2..R10)
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int pick;
      @(negedge clk);
      wrEn = 1'b0;
      if ($urandom_range(0, 3) == 0) padIn = padIn ^ ($urandom & $urandom & $urandom);
      pick = $urandom_range(0, 9);
      if (pick < 3) begin
        int r;
        r = $urandom_range(0, 8);
        wrEn = 1'b1;
        addr = (r == 8) ? 6'h24 : 6'(r * 4);
        wrData = (r == 6) ? ($urandom | $urandom) : $urandom;
        #1;
        checkPins();
      end else begin
        int r;
        r = $urandom_range(0, 8);
        checkRead((r == 8) ? 6'h30 : 6'(r * 4));
        checkPins();
      end
    end
    @(negedge clk);
    wrEn = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule